// File: doc/BRIEF.md
# Pin-State Frame Bridge

This block links a byte stream to the complete pin state of a 40-pin, 8-bit processor socket. A host sends a 5-byte request frame over a byte-wide valid/ready input. The bridge assembles the frame into a 40-bit pin word and drives the socket's input pins from it. After a configurable settle time it samples all 40 socket pins and returns them as a 5-byte response frame over a byte-wide valid/ready output.

The bridge has no clock generator for the processor. The processor clock level is one bit inside every request, so the host advances the processor by one phase per request/response exchange. The data-bus output enable is controlled so that the bridge drives the data pins only while the requested clock level is high and the processor signals a read. Exactly one response follows each request. No new request byte is taken until that response has been fully sent.

Top module: `pin_frame_bridge`

## Requirements
- R1: After synchronous reset `in_ready` is 1, `out_valid` is 0, `sock_drive` is all zeros and `sock_data_oe` is 0.
- R2: Request bytes arrive most significant byte first. The first byte holds bits 39..32 of the pin word and the fifth byte holds bits 7..0, with pin n in bit n-1. `sock_drive` takes the assembled word on the clock edge that accepts the fifth byte.
- R3: `in_ready` is 0 from the edge that accepts a request's fifth byte until the edge that hands over the last response byte. Bytes offered meanwhile are neither accepted nor applied.
- R4: `out_valid` rises SETTLE_CYCLES+1 clock cycles after the edge that accepts the fifth request byte. The response carries `sock_sense` as it stood in the cycle just before `out_valid` rose.
- R5: Response bytes leave most significant byte first, bits 39..32 first, with the same pin-to-bit mapping as requests. Each byte is handed over on a cycle with `out_valid` and `out_ready` both high.
- R6: Bit 20 (pin 21, ground) and bit 34 (pin 35, unconnected) are always 0 in a response, whatever `sock_sense` holds.
- R7: `sock_data_oe` is 1 exactly when bit 36 of the applied word (clock level, pin 37) is 1 and `sock_sense` bit 33 (read/write line, pin 34, high = processor reads) is 1.
- R8: A reset during a partial request discards the bytes already received. The next five bytes form a fresh frame.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R10: `sock_drive` keeps its value from one completed request until the next request completes, including throughout the settle and response phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request byte valid |
| in_data | input | 8 | Request byte |
| in_ready | output | 1 | Bridge accepts a request byte |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer accepts a response byte |
| sock_drive | output | 40 | Pin levels applied to the socket, pin n in bit n-1 |
| sock_data_oe | output | 1 | Drive enable for the data-bus pins (bits 32..25) |
| sock_sense | input | 40 | Pin levels sampled at the socket, pin n in bit n-1 |

## Verification
A wrong byte counter or frame phase shows at the ports within one frame. Either the applied pin word is shifted by a byte, or `in_ready`/`out_valid` toggle on the wrong cycle, and the per-cycle reference comparison catches that on the first cycle it happens. A wrong settle count moves the rise of `out_valid` by whole cycles. A bad sampling point or constant-pin mask changes the returned bytes of the very next response. The output-enable logic is compared every cycle against the applied clock bit and the live read/write level, so a wrong enable shows as soon as either input changes.

// File: rtl/pin_frame_bridge.sv
module pin_frame_bridge #(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  output logic [39:0] sock_drive,
  output logic        sock_data_oe,
  input  logic [39:0] sock_sense
);
  localparam int WORD_W  = 40;
  localparam int BYTES   = WORD_W / 8;
  localparam int CLK_BIT = 36;
  localparam int RW_BIT  = 33;
  localparam int GND_BIT = 20;
  localparam int NC_BIT  = 34;
  localparam int CW      = $clog2(SETTLE_CYCLES + 2);
  localparam logic [WORD_W-1:0] FIXED_ZERO =
    (WORD_W'(1) << GND_BIT) | (WORD_W'(1) << NC_BIT);

  typedef enum logic [1:0] {S_RX, S_SETTLE, S_TX} state_t;

  state_t                 state;
  logic [2:0]             idx;
  logic [8*(BYTES-1)-1:0] shreg;
  logic [WORD_W-1:0]      drive_q;
  logic [WORD_W-1:0]      resp_q;
  logic [CW-1:0]          settle_cnt;

  assign in_ready     = (state == S_RX);
  assign out_valid    = (state == S_TX);
  assign out_data     = resp_q[WORD_W-1 -: 8];
  assign sock_drive   = drive_q;
  assign sock_data_oe = drive_q[CLK_BIT] & sock_sense[RW_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_RX;
      idx        <= '0;
      shreg      <= '0;
      drive_q    <= '0;
      resp_q     <= '0;
      settle_cnt <= '0;
    end else begin
      case (state)
        S_RX: if (in_valid) begin
          if (idx == 3'(BYTES - 1)) begin
            drive_q    <= {shreg, in_data};
            idx        <= '0;
            settle_cnt <= '0;
            state      <= S_SETTLE;
          end else begin
            shreg <= {shreg[8*(BYTES-2)-1:0], in_data};
            idx   <= idx + 3'd1;
          end
        end
        S_SETTLE: begin
          if (settle_cnt == CW'(SETTLE_CYCLES)) begin
            resp_q <= sock_sense & ~FIXED_ZERO;
            idx    <= '0;
            state  <= S_TX;
          end else begin
            settle_cnt <= settle_cnt + CW'(1);
          end
        end
        S_TX: if (out_ready) begin
          resp_q <= resp_q << 8;
          if (idx == 3'(BYTES - 1)) begin
            idx   <= '0;
            state <= S_RX;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        default: state <= S_RX;
      endcase
    end
  end
endmodule

module pin_frame_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic [39:0] sock_drive,
  input logic        clk_level,
  input logic        rw_level,
  input logic        sock_data_oe
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid && sock_drive == 40'd0 && !sock_data_oe));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  a_r7_oe_release: assert property (@(posedge clk) disable iff (rst)
    (!clk_level || !rw_level) |-> !sock_data_oe);

  a_r9_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_drive_hold: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(sock_drive));
endmodule

bind pin_frame_bridge pin_frame_bridge_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .sock_drive(sock_drive),
  .clk_level(sock_drive[36]), .rw_level(sock_sense[33]),
  .sock_data_oe(sock_data_oe)
);

// File: tb/test_pin_frame_bridge.sv
module test_pin_frame_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 3;
  localparam logic [39:0] ZMASK = ~((40'd1 << 20) | (40'd1 << 34));

  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 0;
  logic [39:0] sock_drive;
  logic        sock_data_oe;
  logic [39:0] sock_sense = 0;

  int checks = 0;
  int errors = 0;

  pin_frame_bridge #(.SETTLE_CYCLES(SETTLE)) i_pin_frame_bridge (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .sock_drive(sock_drive),
    .sock_data_oe(sock_data_oe), .sock_sense(sock_sense)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 collect, 1 settle, 2 respond
  int          m_phase = 0;
  logic [7:0]  m_rx[$];
  logic [39:0] m_drive = 0;
  logic [39:0] m_resp = 0;
  int          m_wait = 0;
  int          m_sent = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_rx.delete(); m_drive = 0; m_sent = 0;
    end else if (m_phase == 0) begin
      if (in_valid) begin
        m_rx.push_back(in_data);
        if (m_rx.size() == 5) begin
          m_drive = {m_rx[0], m_rx[1], m_rx[2], m_rx[3], m_rx[4]};
          m_rx.delete();
          m_phase = 1; m_wait = 0;
        end
      end
    end else if (m_phase == 1) begin
      if (m_wait == SETTLE) begin
        m_resp = sock_sense & ZMASK; m_phase = 2; m_sent = 0;
      end else m_wait++;
    end else begin
      if (out_ready) begin
        m_sent++;
        if (m_sent == 5) m_phase = 0;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    chk(in_ready === (m_phase == 0), "R3 in_ready", 40'(in_ready), 40'(m_phase == 0));
    chk(out_valid === (m_phase == 2), "R4 out_valid", 40'(out_valid), 40'(m_phase == 2));
    if (m_phase == 2)
      chk(out_data === m_resp[39-8*m_sent -: 8], "R5 out_data", 40'(out_data), 40'(m_resp[39-8*m_sent -: 8]));
    chk(sock_drive === m_drive, "R2 sock_drive", sock_drive, m_drive);
    chk(sock_data_oe === (m_drive[36] & sock_sense[33]), "R7 sock_data_oe",
        40'(sock_data_oe), 40'(m_drive[36] & sock_sense[33]));
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_data = b;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic xact(input logic [39:0] req, input logic [39:0] sense, input bit junk, input bit gaps);
    logic [39:0] exp;
    logic [7:0]  got[5];
    logic [7:0]  prev_data;
    bit          prev_hold;
    int          n, k;
    exp = sense & ZMASK;
    @(negedge clk);
    sock_sense = sense;
    for (int i = 0; i < 5; i++) send_byte(req[39-8*i -: 8]);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      in_valid = junk; in_data = 8'hAA;
    end while (!out_valid && k < 100);
    chk(k == SETTLE + 2, "R4 latency", 40'(k), 40'(SETTLE + 2));
    chk(in_ready === 1'b0, "R3 busy during response", 40'(in_ready), 40'd0);
    n = 0; prev_hold = 0; prev_data = 0;
    for (int c = 0; n < 5 && c < 200; c++) begin
      if (c > 0) @(negedge clk);
      if (prev_hold)
        chk(out_valid === 1'b1 && out_data === prev_data, "R9 hold", 40'(out_data), 40'(prev_data));
      out_ready = gaps ? ((c % 3) != 1) : 1'b1;
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (out_valid && out_ready) begin
        got[n] = out_data; n++;
        if (n == 5) in_valid = 0;
      end
    end
    @(negedge clk);
    out_ready = 0;
    for (int i = 0; i < 5; i++)
      chk(got[i] === exp[39-8*i -: 8], "R5 R6 response byte", 40'(got[i]), 40'(exp[39-8*i -: 8]));
    chk(sock_drive === req, "R10 drive kept", sock_drive, req);
    chk(in_ready === 1'b1, "R3 ready after response", 40'(in_ready), 40'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 handshake idle", {38'd0, in_ready, out_valid}, 40'd2);
    chk(sock_drive === 40'd0 && sock_data_oe === 1'b0, "R1 pins cleared", sock_drive, 40'd0);

    xact(40'h12_3456_789A, 40'hFE_DCBA_9876, 0, 0);
    xact(40'h10_0000_0001, 40'h02_0000_0000, 0, 1);
    chk(sock_data_oe === 1'b1, "R7 oe clock high read", 40'(sock_data_oe), 40'd1);
    sock_sense = 40'h00_0000_0000;
    @(negedge clk);
    chk(sock_data_oe === 1'b0, "R7 oe on write", 40'(sock_data_oe), 40'd0);
    xact(40'h00_FFFF_FFFF, 40'hFF_FFFF_FFFF, 1, 1);
    chk(sock_data_oe === 1'b0, "R7 oe clock low", 40'(sock_data_oe), 40'd0);
    xact(40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 0, 0);

    // R8: partial frame dropped by reset
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h77);
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R8 idle after reset", {38'd0, in_ready, out_valid}, 40'd2);
    xact(40'hA5_5A0F_F0C3, 40'h5A_A5F0_0F3C, 0, 1);
    chk(sock_drive === 40'hA5_5A0F_F0C3, "R8 fresh frame", sock_drive, 40'hA5_5A0F_F0C3);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule